// File: doc/BRIEF.md
# SPI Master Register File

This block is the software-visible register file of an SPI master. A simple single-cycle register port reads and writes a control word, a frame width, a 32-bit frame count kept in two places, a serial clock divider, a select-line register and three interrupt views: raw, masked, and a write-one-to-clear port. The block drives the configuration fields to the shift datapath as plain signals. It also decodes the transmit-data and receive-data addresses into push and pop strobes for the FIFOs, which sit outside this block.

The datapath reports back through four event pulses and a few level signals. The event pulses are transmit done, receive ready, receive overflow and transmit underrun. The level signals are transfer active, message done, frame start and eight FIFO flags. The events set sticky raw interrupt bits. Those bits are gated by the enable bits in the control word to form a single interrupt line. While the block is enabled, the frame width and the frame count are frozen, so a transfer in flight cannot have its length changed under it.

The select lines are produced here. In direct mode software drives them outright. In automatic mode a line follows transfer activity, and it can be held asserted across gaps until the message ends.

Top module: `spim_csr`

## Requirements
- R1: After reset, control (offset 0x00) reads 0x8000_0000, frame width (0x04), frame count (0x50), select register (0x1C) and raw interrupts (0x24) read 0, `irq_o` is low and every select line sits at its idle level (high, as the lines are active low).
- R2: Control bit positions are: 0 enable, 1 master, 3:2 protocol, 7:4 interrupt enables, 23:8 low frame count, 24 polarity, 25 phase, 26 select-hold, 28 clock mode, 29 wide FIFO, 31 soft reset. Bits 27 and 30 read as 0. Each stored bit appears on its `cfg_*` output.
- R3: A write to the frame width register (0x04, low 6 bits) takes effect only if the enable bit was clear before the write. Otherwise the stored value is unchanged.
- R4: The frame count is 32 bits. Bits 15:0 are written through control bits 23:8, and bits 31:16 through bits 31:16 of a write to 0x50. Reading 0x50 returns all 32 bits, and the low half of a write to 0x50 is discarded.
- R5: While the enable bit is set (before the write), writes to either part of the frame count leave it unchanged, but the other control fields of a control write still update.
- R6: An event pulse on `event_i[k]` sets raw interrupt bit k (0 transmit done, 1 receive ready, 2 overflow, 3 underrun). Raw bits read at 0x24 and also appear in status bits 3:0.
- R7: Writing ones to 0x0C clears the matching raw bits and zeros leave them alone. An event arriving in the same cycle as its clear leaves the bit set.
- R8: Masked status (0x20) is raw AND enables, where control bit 4 gates raw bit 1, bit 5 gates raw bit 0, bit 6 gates raw bit 2 and bit 7 gates raw bit 3. `irq_o` is the OR of the masked bits.
- R9: Select register bits 7:0 pick lines, bit 8 selects direct mode and bit 9 enables the outputs. In direct mode with outputs on, line k is asserted (low) exactly when bit k is set.
- R10: In automatic mode with outputs on, line k is asserted when bit k is set and either the transfer is active or a hold latch is set. The hold latch sets while active with select-hold on, and clears on `msg_done_i` or when enable is clear.
- R11: With select register bit 9 clear, all select lines are at the idle level whatever the other bits are.
- R12: Status (0x08) reports transfer active in bit 14, any select line asserted in bit 13, frame start in bit 12 and the FIFO flags in bits 11:4.
- R13: A write to 0x14 pulses `tx_push_o` for that cycle with the low data bits on `tx_data_o`. A read of 0x10 returns `rx_data_i` and raises `rx_pop_o`. The clock divider at 0x18 reads back its low 8 bits and drives `cfg_clk_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| cfg_enable | output | 1 | Block enable |
| cfg_master | output | 1 | Master mode |
| cfg_proto | output | 2 | Protocol select |
| cfg_cpol | output | 1 | Clock polarity |
| cfg_cpha | output | 1 | Clock phase |
| cfg_sel_hold | output | 1 | Keep select through the message |
| cfg_clk_mode | output | 1 | Divider law select |
| cfg_big_fifo | output | 1 | Wide FIFO mode |
| cfg_soft_reset | output | 1 | Soft reset request |
| cfg_frame_size | output | 6 | Frame width |
| cfg_frame_count | output | 32 | Frames per transfer |
| cfg_clk_div | output | 8 | Serial clock divider |
| tx_push_o | output | 1 | Transmit FIFO push |
| tx_data_o | output | 8 | Transmit data |
| rx_pop_o | output | 1 | Receive FIFO pop |
| rx_data_i | input | 8 | Receive FIFO head |
| xfer_active_i | input | 1 | Transfer in progress |
| msg_done_i | input | 1 | Message finished pulse |
| frame_start_i | input | 1 | Frame start indication |
| fifo_flags_i | input | 8 | FIFO full/empty flags |
| event_i | input | 4 | Interrupt event pulses |
| irq_o | output | 1 | Interrupt request |
| ss_o | output | 8 | Select lines, active low |

## Verification
Two cases can fall in the same cycle. The first is an event pulse and a software clear of the same interrupt bit. The second is a configuration write arriving while the enable bit is set. The bench drives the event vector together with writes to the clear register, once on purpose and then at random. It expects the event to win and the raw, masked and interrupt outputs to match a bench model. It also writes the frame width and both halves of the count in the cycles right after enabling. It judges these writes by reading the registers back and expecting the locked values, while the other control fields from the same write are expected to change.

// File: rtl/spim_csr_pkg.sv
package spim_csr_pkg;
   localparam int OFS_CTRL   = 'h00;
   localparam int OFS_FSIZE  = 'h04;
   localparam int OFS_STAT   = 'h08;
   localparam int OFS_CLR    = 'h0C;
   localparam int OFS_RXD    = 'h10;
   localparam int OFS_TXD    = 'h14;
   localparam int OFS_CDIV   = 'h18;
   localparam int OFS_SEL    = 'h1C;
   localparam int OFS_MASKED = 'h20;
   localparam int OFS_RAW    = 'h24;
   localparam int OFS_CNTHI  = 'h50;

   localparam int CB_EN     = 0;
   localparam int CB_MST    = 1;
   localparam int CB_PROTO  = 2;
   localparam int CB_IE     = 4;
   localparam int CB_CNT    = 8;
   localparam int CB_CPOL   = 24;
   localparam int CB_CPHA   = 25;
   localparam int CB_HOLD   = 26;
   localparam int CB_CKMODE = 28;
   localparam int CB_BIGF   = 29;
   localparam int CB_SRST   = 31;

   localparam int NIRQ = 4;

   localparam logic [31:0] CTRL_RW_MASK = 32'hB7FF_FFFF;
   localparam logic [31:0] CTRL_CNT_FLD = 32'h00FF_FF00;
   localparam logic [31:0] CTRL_RESET   = 32'h8000_0000;

   localparam int SB_ACTIVE = 14;
   localparam int SB_SEL    = 13;
   localparam int SB_FSTART = 12;
   localparam int SB_FLAGS  = 4;
endpackage

// File: rtl/spim_cfg_regs.sv
module spim_cfg_regs
   import spim_csr_pkg::*;
#(
   parameter int FSIZE_W = 6,
   parameter int CDIV_W  = 8,
   parameter int NUM_SEL = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ctrl,
   input  logic               wr_fsize,
   input  logic               wr_cnthi,
   input  logic               wr_cdiv,
   input  logic               wr_sel,
   input  logic [31:0]        wdata,
   output logic [31:0]        ctrl_q,
   output logic [FSIZE_W-1:0] fsize_q,
   output logic [15:0]        cnt_lo_q,
   output logic [15:0]        cnt_hi_q,
   output logic [CDIV_W-1:0]  cdiv_q,
   output logic [NUM_SEL-1:0] sel_bits_q,
   output logic               sel_direct_q,
   output logic               sel_outen_q
);
   logic locked;
   assign locked = ctrl_q[CB_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
      end else if (wr_ctrl) begin
         ctrl_q <= wdata & CTRL_RW_MASK & ~CTRL_CNT_FLD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsize_q  <= '0;
         cnt_lo_q <= '0;
         cnt_hi_q <= '0;
      end else if (!locked) begin
         if (wr_fsize) fsize_q  <= wdata[FSIZE_W-1:0];
         if (wr_ctrl)  cnt_lo_q <= wdata[CB_CNT +: 16];
         if (wr_cnthi) cnt_hi_q <= wdata[31:16];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cdiv_q       <= '0;
         sel_bits_q   <= '0;
         sel_direct_q <= 1'b0;
         sel_outen_q  <= 1'b0;
      end else begin
         if (wr_cdiv) cdiv_q <= wdata[CDIV_W-1:0];
         if (wr_sel) begin
            sel_bits_q   <= wdata[NUM_SEL-1:0];
            sel_direct_q <= wdata[8];
            sel_outen_q  <= wdata[9];
         end
      end
   end

   // R3
   fsize_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(fsize_q));

   // R5
   cnt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> ($stable(cnt_lo_q) && $stable(cnt_hi_q)));
endmodule

// File: rtl/spim_irq_unit.sv
module spim_irq_unit
   import spim_csr_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] event_i,
   input  logic [NIRQ-1:0] clr_i,
   input  logic [NIRQ-1:0] en_i,
   output logic [NIRQ-1:0] raw_q,
   output logic [NIRQ-1:0] masked_o,
   output logic            irq_o
);
   for (genvar k = 0; k < NIRQ; k++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            raw_q[k] <= 1'b0;
         else if (event_i[k])
            raw_q[k] <= 1'b1;
         else if (clr_i[k])
            raw_q[k] <= 1'b0;
      end

      // R7
      ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         event_i[k] |=> raw_q[k]);

      // R7
      clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[k] && !event_i[k]) |=> !raw_q[k]);
   end

   assign masked_o = raw_q & en_i;
   assign irq_o    = |masked_o;
endmodule

// File: rtl/spim_sel_drive.sv
module spim_sel_drive #(
   parameter int NUM_SEL    = 8,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable_i,
   input  logic               hold_en_i,
   input  logic               xfer_active_i,
   input  logic               msg_done_i,
   input  logic [NUM_SEL-1:0] sel_bits_i,
   input  logic               direct_i,
   input  logic               outen_i,
   output logic [NUM_SEL-1:0] ss_o,
   output logic               any_sel_o
);
   localparam logic [NUM_SEL-1:0] IDLE_LEVEL = ACTIVE_LOW ? '1 : '0;

   logic               hold_q;
   logic [NUM_SEL-1:0] asserted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= 1'b0;
      else if (!enable_i || msg_done_i)
         hold_q <= 1'b0;
      else if (hold_en_i && xfer_active_i)
         hold_q <= 1'b1;
   end

   for (genvar k = 0; k < NUM_SEL; k++) begin : g_line
      assign asserted[k] = outen_i && sel_bits_i[k] &&
                           (direct_i || xfer_active_i || hold_q);
   end

   if (ACTIVE_LOW) begin : g_low
      assign ss_o = ~asserted;
   end else begin : g_high
      assign ss_o = asserted;
   end

   assign any_sel_o = |asserted;

   // R11
   outen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !outen_i |-> (ss_o == IDLE_LEVEL));

   // R10
   hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && hold_en_i && xfer_active_i && !msg_done_i) |=> hold_q);

   // R10
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_done_i |=> !hold_q);
endmodule

// File: rtl/spim_csr.sv
module spim_csr
   import spim_csr_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int FSIZE_W    = 6,
   parameter int CDIV_W     = 8,
   parameter int NUM_SEL    = 8,
   parameter bit SEL_ACTIVE_LOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               cfg_enable,
   output logic               cfg_master,
   output logic [1:0]         cfg_proto,
   output logic               cfg_cpol,
   output logic               cfg_cpha,
   output logic               cfg_sel_hold,
   output logic               cfg_clk_mode,
   output logic               cfg_big_fifo,
   output logic               cfg_soft_reset,
   output logic [FSIZE_W-1:0] cfg_frame_size,
   output logic [31:0]        cfg_frame_count,
   output logic [CDIV_W-1:0]  cfg_clk_div,
   output logic               tx_push_o,
   output logic [DATA_W-1:0]  tx_data_o,
   output logic               rx_pop_o,
   input  logic [DATA_W-1:0]  rx_data_i,
   input  logic               xfer_active_i,
   input  logic               msg_done_i,
   input  logic               frame_start_i,
   input  logic [7:0]         fifo_flags_i,
   input  logic [NIRQ-1:0]    event_i,
   output logic               irq_o,
   output logic [NUM_SEL-1:0] ss_o
);
   if (ADDR_W < 7 || ADDR_W > 32) begin : g_bad_addr
      $error("spim_csr: ADDR_W must lie in 7..32");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
      $error("spim_csr: DATA_W must lie in 1..32");
   end
   if (FSIZE_W < 1 || FSIZE_W > 32) begin : g_bad_fsize
      $error("spim_csr: FSIZE_W must lie in 1..32");
   end
   if (CDIV_W < 1 || CDIV_W > 32) begin : g_bad_cdiv
      $error("spim_csr: CDIV_W must lie in 1..32");
   end
   if (NUM_SEL < 1 || NUM_SEL > 8) begin : g_bad_sel
      $error("spim_csr: NUM_SEL must lie in 1..8");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic [31:0]        ctrl_q;
   logic [FSIZE_W-1:0] fsize_q;
   logic [15:0]        cnt_lo_q, cnt_hi_q;
   logic [CDIV_W-1:0]  cdiv_q;
   logic [NUM_SEL-1:0] sel_bits_q;
   logic               sel_direct_q, sel_outen_q;
   logic [NIRQ-1:0]    raw_q, masked, irq_en, clr_vec;
   logic               any_sel;
   logic [31:0]        frame_count;

   spim_cfg_regs #(
      .FSIZE_W(FSIZE_W), .CDIV_W(CDIV_W), .NUM_SEL(NUM_SEL)
   ) cfg_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ctrl     (reg_wr && hit(reg_addr, OFS_CTRL)),
      .wr_fsize    (reg_wr && hit(reg_addr, OFS_FSIZE)),
      .wr_cnthi    (reg_wr && hit(reg_addr, OFS_CNTHI)),
      .wr_cdiv     (reg_wr && hit(reg_addr, OFS_CDIV)),
      .wr_sel      (reg_wr && hit(reg_addr, OFS_SEL)),
      .wdata       (reg_wdata),
      .ctrl_q      (ctrl_q),
      .fsize_q     (fsize_q),
      .cnt_lo_q    (cnt_lo_q),
      .cnt_hi_q    (cnt_hi_q),
      .cdiv_q      (cdiv_q),
      .sel_bits_q  (sel_bits_q),
      .sel_direct_q(sel_direct_q),
      .sel_outen_q (sel_outen_q)
   );

   // enable bit order: rx-data, tx-data, overflow, underrun -> raw bit order
   assign irq_en  = {ctrl_q[CB_IE+3], ctrl_q[CB_IE+2], ctrl_q[CB_IE+0], ctrl_q[CB_IE+1]};
   assign clr_vec = (reg_wr && hit(reg_addr, OFS_CLR)) ? reg_wdata[NIRQ-1:0] : '0;

   spim_irq_unit irq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_i (event_i),
      .clr_i   (clr_vec),
      .en_i    (irq_en),
      .raw_q   (raw_q),
      .masked_o(masked),
      .irq_o   (irq_o)
   );

   spim_sel_drive #(
      .NUM_SEL(NUM_SEL), .ACTIVE_LOW(SEL_ACTIVE_LOW)
   ) sel_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable_i     (ctrl_q[CB_EN]),
      .hold_en_i    (ctrl_q[CB_HOLD]),
      .xfer_active_i(xfer_active_i),
      .msg_done_i   (msg_done_i),
      .sel_bits_i   (sel_bits_q),
      .direct_i     (sel_direct_q),
      .outen_i      (sel_outen_q),
      .ss_o         (ss_o),
      .any_sel_o    (any_sel)
   );

   assign frame_count = {cnt_hi_q, cnt_lo_q};

   assign cfg_enable      = ctrl_q[CB_EN];
   assign cfg_master      = ctrl_q[CB_MST];
   assign cfg_proto       = ctrl_q[CB_PROTO +: 2];
   assign cfg_cpol        = ctrl_q[CB_CPOL];
   assign cfg_cpha        = ctrl_q[CB_CPHA];
   assign cfg_sel_hold    = ctrl_q[CB_HOLD];
   assign cfg_clk_mode    = ctrl_q[CB_CKMODE];
   assign cfg_big_fifo    = ctrl_q[CB_BIGF];
   assign cfg_soft_reset  = ctrl_q[CB_SRST];
   assign cfg_frame_size  = fsize_q;
   assign cfg_frame_count = frame_count;
   assign cfg_clk_div     = cdiv_q;

   assign tx_push_o = reg_wr && hit(reg_addr, OFS_TXD);
   assign tx_data_o = reg_wdata[DATA_W-1:0];
   assign rx_pop_o  = reg_rd && hit(reg_addr, OFS_RXD);

   always_comb begin
      reg_rdata = '0;
      if (hit(reg_addr, OFS_CTRL))
         reg_rdata = ctrl_q | ({16'b0, cnt_lo_q} << CB_CNT);
      else if (hit(reg_addr, OFS_FSIZE))
         reg_rdata = 32'(fsize_q);
      else if (hit(reg_addr, OFS_STAT)) begin
         reg_rdata[NIRQ-1:0]         = raw_q;
         reg_rdata[SB_FLAGS +: 8]    = fifo_flags_i;
         reg_rdata[SB_FSTART]        = frame_start_i;
         reg_rdata[SB_SEL]           = any_sel;
         reg_rdata[SB_ACTIVE]        = xfer_active_i;
      end
      else if (hit(reg_addr, OFS_RXD))
         reg_rdata = 32'(rx_data_i);
      else if (hit(reg_addr, OFS_CDIV))
         reg_rdata = 32'(cdiv_q);
      else if (hit(reg_addr, OFS_SEL))
         reg_rdata = {22'b0, sel_outen_q, sel_direct_q, 8'(sel_bits_q)};
      else if (hit(reg_addr, OFS_MASKED))
         reg_rdata = 32'(masked);
      else if (hit(reg_addr, OFS_RAW))
         reg_rdata = 32'(raw_q);
      else if (hit(reg_addr, OFS_CNTHI))
         reg_rdata = frame_count;
   end

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q == '0) |-> !irq_o);
endmodule

// File: tb/spim_csr_tb_top.sv
module spim_csr_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cfg_enable, cfg_master, cfg_cpol, cfg_cpha, cfg_sel_hold;
   logic        cfg_clk_mode, cfg_big_fifo, cfg_soft_reset;
   logic [1:0]  cfg_proto;
   logic [5:0]  cfg_frame_size;
   logic [31:0] cfg_frame_count;
   logic [7:0]  cfg_clk_div;
   logic        tx_push_o, rx_pop_o, irq_o;
   logic [7:0]  tx_data_o;
   logic [7:0]  rx_data_i = '0;
   logic        xfer_active_i = 1'b0, msg_done_i = 1'b0, frame_start_i = 1'b0;
   logic [7:0]  fifo_flags_i = '0;
   logic [3:0]  event_i = '0;
   logic [7:0]  ss_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spim_csr dut_i (.*);

   // bench model
   logic [31:0] m_ctrl;
   logic [31:0] m_cnt;
   logic [5:0]  m_fs;
   logic [3:0]  m_raw;

   function automatic logic [31:0] exp_ctrl(input logic [31:0] c, input logic [31:0] n);
      return (c & 32'hB7FF_FFFF & ~32'h00FF_FF00) | {8'b0, n[15:0], 8'b0};
   endfunction

   function automatic logic [3:0] exp_masked(input logic [3:0] r, input logic [31:0] c);
      logic [3:0] e;
      e = {c[7], c[6], c[4], c[5]};
      return r & e;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] ev);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; event_i = ev;
      @(negedge clk);
      reg_wr = 1'b0; event_i = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      #1 reg_rd = 1'b0;
   endtask

   task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   // model of a write cycle
   task automatic mwr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] ev);
      logic en_before;
      en_before = m_ctrl[0];
      wr(a, d, ev);
      if (a == 8'h0C) m_raw = m_raw & ~d[3:0];
      m_raw = m_raw | ev;
      if (a == 8'h00) begin
         m_ctrl = d & 32'hB7FF_FFFF & ~32'h00FF_FF00;
         if (!en_before) m_cnt[15:0] = d[23:8];
      end
      if (a == 8'h04 && !en_before) m_fs = d[5:0];
      if (a == 8'h50 && !en_before) m_cnt[31:16] = d[31:16];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h5EED_1234));
      m_ctrl = 32'h8000_0000; m_cnt = '0; m_fs = '0; m_raw = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rdchk("R1 ctrl", 8'h00, 32'h8000_0000);
      rdchk("R1 fsize", 8'h04, 0);
      rdchk("R1 count", 8'h50, 0);
      rdchk("R1 sel", 8'h1C, 0);
      rdchk("R1 raw", 8'h24, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 ss", ss_o, 8'hFF);

      // R2 field placement
      mwr(8'h00, 32'hFFFF_FFFE, 0);
      rdchk("R2 ctrl readback", 8'h00, 32'hB7FF_FFFE);
      chk("R2 cfg fields", {cfg_soft_reset, cfg_big_fifo, cfg_clk_mode, cfg_sel_hold,
          cfg_cpha, cfg_cpol, cfg_proto, cfg_master, cfg_enable}, 10'b1111111110);
      mwr(8'h00, 32'h0100_0004, 0);
      chk("R2 cpol/proto", {cfg_cpol, cfg_cpha, cfg_proto}, 4'b1001);

      // R4 split frame count
      mwr(8'h00, 32'h0000_3400, 0);
      mwr(8'h50, 32'hABCD_9999, 0);
      rdchk("R4 count full", 8'h50, 32'hABCD_0034);
      chk("R4 cfg count", cfg_frame_count, 32'hABCD_0034);
      rdchk("R4 ctrl low count", 8'h00, 32'h0000_3400);

      // R3 frame width while disabled
      mwr(8'h04, 32'hFFFF_FFEA, 0);
      rdchk("R3 fsize masked", 8'h04, 32'h2A);

      // R3 R5 locks once enabled
      mwr(8'h00, 32'h0000_1201, 0);
      mwr(8'h04, 32'h0000_0005, 0);
      rdchk("R3 fsize locked", 8'h04, 32'h2A);
      mwr(8'h00, 32'h0000_FF03, 0);
      rdchk("R5 low count locked, master set", 8'h00, 32'h0000_1203);
      mwr(8'h50, 32'h1111_0000, 0);
      rdchk("R5 high count locked", 8'h50, 32'hABCD_0012);

      // R6 events
      mwr(8'h00, 32'h0000_0000, 0);
      mwr(8'h24, 0, 4'b0101);
      rdchk("R6 raw", 8'h24, 32'h5);
      rdchk("R6 status low", 8'h08, 32'h5);
      chk("R8 irq off with no enables", irq_o, 0);
      // R8 enables: bit5 gates raw0
      mwr(8'h00, 32'h0000_0020, 0);
      rdchk("R8 masked", 8'h20, 32'h1);
      chk("R8 irq", irq_o, 1);
      mwr(8'h00, 32'h0000_00D0, 4'b1010);
      rdchk("R8 masked all", 8'h20, {28'b0, exp_masked(4'hF, 32'hD0)});
      // R7 clear and collision
      mwr(8'h0C, 32'h0000_0006, 0);
      rdchk("R7 clear", 8'h24, 32'h9);
      mwr(8'h0C, 32'h0000_0001, 4'b0001);
      rdchk("R7 event wins", 8'h24, 32'h9);
      mwr(8'h0C, 32'hF, 0);
      rdchk("R7 clear all", 8'h24, 0);
      chk("R8 irq cleared", irq_o, 0);

      // R9 R11 R12 select
      mwr(8'h1C, 32'h305, 0);
      chk("R9 direct", ss_o, 8'hFA);
      rdchk("R12 select status", 8'h08, 32'h2000);
      mwr(8'h1C, 32'h105, 0);
      chk("R11 outputs off", ss_o, 8'hFF);
      // R10 automatic
      mwr(8'h1C, 32'h201, 0);
      chk("R10 idle", ss_o, 8'hFF);
      @(negedge clk); xfer_active_i = 1'b1; #1;
      chk("R10 active", ss_o, 8'hFE);
      @(negedge clk); xfer_active_i = 1'b0; #1;
      chk("R10 no hold releases", ss_o, 8'hFF);
      mwr(8'h00, 32'h0400_0001, 0);
      @(negedge clk); xfer_active_i = 1'b1;
      @(negedge clk); xfer_active_i = 1'b0; #1;
      chk("R10 hold keeps", ss_o, 8'hFE);
      @(negedge clk); #1;
      chk("R10 hold still", ss_o, 8'hFE);
      msg_done_i = 1'b1;
      @(negedge clk); msg_done_i = 1'b0; #1;
      chk("R10 msg done releases", ss_o, 8'hFF);
      mwr(8'h00, 32'h0, 0);
      m_cnt[15:0] = 16'h0;

      // R12 status levels
      xfer_active_i = 1'b1; frame_start_i = 1'b1; fifo_flags_i = 8'hC3;
      rdchk("R12 status", 8'h08, 32'h0000_7C30 | 32'h0);
      xfer_active_i = 1'b0; frame_start_i = 1'b0; fifo_flags_i = 8'h00;

      // R13 data and divider
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h0000_01A5; #1;
      chk("R13 push", {tx_push_o, tx_data_o}, 9'h1A5);
      @(negedge clk); reg_wr = 1'b0; #1;
      chk("R13 push ends", tx_push_o, 0);
      rx_data_i = 8'h3C;
      reg_rd = 1'b1; reg_addr = 8'h10; #1;
      chk("R13 pop", {rx_pop_o, reg_rdata}, {1'b1, 32'h3C});
      reg_rd = 1'b0;
      mwr(8'h18, 32'h0000_0123, 0);
      rdchk("R13 divider", 8'h18, 32'h23);
      chk("R13 cfg divider", cfg_clk_div, 8'h23);

      // random mix against the model
      mwr(8'h0C, 32'hF, 0);
      for (int i = 0; i < 400; i++) begin
         logic [7:0]  a;
         logic [31:0] dd;
         logic [3:0]  ev;
         case ($urandom_range(0, 3))
            0: a = 8'h00;
            1: a = 8'h04;
            2: a = 8'h50;
            default: a = 8'h0C;
         endcase
         dd = $urandom();
         ev = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'h0;
         mwr(a, dd, ev);
         rdchk("R2 R5 rand ctrl", 8'h00, exp_ctrl(m_ctrl, m_cnt));
         rdchk("R3 rand fsize", 8'h04, {26'b0, m_fs});
         rdchk("R4 rand count", 8'h50, m_cnt);
         rdchk("R7 rand raw", 8'h24, {28'b0, m_raw});
         rdchk("R8 rand masked", 8'h20, {28'b0, exp_masked(m_raw, m_ctrl)});
         chk("R8 rand irq", irq_o, |exp_masked(m_raw, m_ctrl));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule